// File: doc/BRIEF.md
# SD Multi-Block Stop Sequencer

This block sits beside the command engine of an SD host controller. It decides when the stop-transmission command (CMD12) has to go out during a multi-block data transfer. Two events start the stop. The first is a software stop bit held in a small control register. The second is a programmed block count that counts down to zero on completed data blocks, when software has enabled counting.

The block waits for the card to leave its busy state after an R1b response. It then gives the command engine a single-cycle request together with a fixed all-zero argument. When the CMD12 response comes back, it raises a sticky auto-stop-complete flag, which software clears by writing one. If the command sequence has already ended, a stop request causes no command at all.

Top module: `sd_stop_sequencer`

## Requirements
- R1: After reset the control register reads 0, the block count reads 0, the auto-stop flag is 0 and no stop request is driven.
- R2: The control register keeps only bit 0 (stop) and bit 8 (block-count enable). A read returns those two bits in place and zero in every other position, whatever was written there.
- R3: Setting the stop bit while a transfer is active produces one stop-command request.
- R4: Whenever the stop request is high, the stop-command argument output is all zeros.
- R5: With block counting enabled, each completed data block during an active transfer lowers the count by one. The block that brings the count from 1 to 0 produces one stop-command request.
- R6: With block counting disabled, completed data blocks leave the count unchanged and produce no stop request.
- R7: Once the command sequence has completed, setting the stop bit produces no request and the auto-stop flag stays 0.
- R8: While the card-busy input is high, no stop request is issued. A held request goes out once busy falls.
- R9: The stop request is a one-cycle pulse. No further request comes until a new transfer starts or the flag is cleared.
- R10: The auto-stop flag goes to 1 when the response to the issued stop command arrives. It stays 1 until a flag-clear pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctrl_wr_en | input | 1 | Write strobe for the control register |
| ctrl_wr_data | input | CTRL_W | Control write data (bit 0 stop, bit 8 count enable) |
| ctrl_rd_data | output | CTRL_W | Control register read value |
| cnt_wr_en | input | 1 | Write strobe for the block count |
| cnt_wr_data | input | CNT_W | Block count load value |
| cnt_rd_data | output | CNT_W | Current block count |
| flag_clr | input | 1 | Write-one-to-clear pulse for the auto-stop flag |
| xfer_start | input | 1 | A multi-block transfer begins |
| rsp_recv | input | 1 | A command response has been received |
| blk_done | input | 1 | One data block completed |
| seq_done | input | 1 | The command sequence has completed |
| card_busy | input | 1 | Card busy after an R1b response |
| stop_cmd_req | output | 1 | One-cycle request to send CMD12 |
| stop_cmd_arg | output | ARG_W | Argument for CMD12 |
| auto_stop_flag | output | 1 | Sticky auto-stop-complete flag |

## Verification
The bench builds the block with a 4-bit block count. Every load value from 1 to 15 can therefore be reached, and counted all the way down, within a short run. The control register keeps its default 16-bit width, so bit 8 and all the reserved positions around it are exercised. Random transfers mix count-driven stops, stop-bit stops with counting disabled, and early sequence completion. Random busy windows are placed over the pending stop.

// File: rtl/sd_stop_pkg.sv
package sd_stop_pkg;

  localparam int unsigned CTRL_STOP_POS = 0;
  localparam int unsigned CTRL_BCEN_POS = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XFER,
    ST_PEND,
    ST_WAIT,
    ST_DONE
  } stop_state_e;

endpackage

// File: rtl/sd_stop_ctrl_reg.sv
module sd_stop_ctrl_reg
  import sd_stop_pkg::*;
#(
  parameter int unsigned CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic              stop_q,
  output logic              bcen_q,
  output logic [CTRL_W-1:0] rd_data
);

  function automatic logic [CTRL_W-1:0] ctrl_image(input logic s, input logic b);
    logic [CTRL_W-1:0] img;
    img = '0;
    img[CTRL_STOP_POS] = s;
    img[CTRL_BCEN_POS] = b;
    return img;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      bcen_q <= 1'b0;
    end else if (wr_en) begin
      stop_q <= wr_data[CTRL_STOP_POS];
      bcen_q <= wr_data[CTRL_BCEN_POS];
    end
  end

  assign rd_data = ctrl_image(stop_q, bcen_q);

  assert_wr_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[CTRL_STOP_POS] == $past(wr_data[CTRL_STOP_POS])));

  assert_wr_bcen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[CTRL_BCEN_POS] == $past(wr_data[CTRL_BCEN_POS])));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));

endmodule

// File: rtl/sd_stop_blk_counter.sv
module sd_stop_blk_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             count_en,
  input  logic             active,
  input  logic             blk_done,
  output logic [CNT_W-1:0] cnt_q,
  output logic             hit_zero
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] dec_value(input logic [CNT_W-1:0] c);
    return c - ONE;
  endfunction

  logic dec_evt;

  assign dec_evt  = count_en && active && blk_done && (cnt_q != '0);
  assign hit_zero = dec_evt && (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (load_en)  cnt_q <= load_val;
    else if (dec_evt)  cnt_q <= dec_value(cnt_q);
  end

  assert_dec_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_evt && !load_en) |=> (cnt_q == $past(cnt_q) - ONE));

  assert_hold_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !load_en) |=> $stable(cnt_q));

  assert_zero_only_from_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_zero |=> (cnt_q == '0 || $past(load_en)));

endmodule

// File: rtl/sd_stop_fsm.sv
module sd_stop_fsm
  import sd_stop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stop_q,
  input  logic hit_zero,
  input  logic xfer_start,
  input  logic seq_done,
  input  logic rsp_recv,
  input  logic card_busy,
  input  logic flag_clr,
  output logic active,
  output logic cmd_req,
  output logic flag_q
);

  stop_state_e state_q, state_d;
  logic        issue;
  logic        rsp_evt;
  logic        issued_q;

  assign issue   = (state_q == ST_PEND) && !seq_done && !card_busy;
  assign rsp_evt = (state_q == ST_WAIT) && rsp_recv;
  assign active  = (state_q == ST_XFER);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (xfer_start) state_d = ST_XFER;
      ST_XFER: begin
        if (seq_done)                state_d = ST_IDLE;
        else if (stop_q || hit_zero) state_d = ST_PEND;
      end
      ST_PEND: begin
        if (seq_done)   state_d = ST_IDLE;
        else if (issue) state_d = ST_WAIT;
      end
      ST_WAIT: if (rsp_evt) state_d = ST_DONE;
      ST_DONE: begin
        if (xfer_start)    state_d = ST_XFER;
        else if (flag_clr) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cmd_req <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cmd_req <= issue;
      if (rsp_evt)       flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  // verification tracker: a request has gone out since the last start or clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      issued_q <= 1'b0;
    else if (xfer_start || flag_clr) issued_q <= 1'b0;
    else if (cmd_req)                issued_q <= 1'b1;
  end

  assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |=> !cmd_req);

  assert_one_per_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |-> !issued_q);

  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PEND && card_busy) |=> !cmd_req);

  assert_idle_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |=> !cmd_req);

  assert_flag_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(rsp_recv));

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);

endmodule

// File: rtl/sd_stop_sequencer.sv
module sd_stop_sequencer #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned CTRL_W = 16,
  parameter int unsigned ARG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr_en,
  input  logic [CTRL_W-1:0] ctrl_wr_data,
  output logic [CTRL_W-1:0] ctrl_rd_data,
  input  logic              cnt_wr_en,
  input  logic [CNT_W-1:0]  cnt_wr_data,
  output logic [CNT_W-1:0]  cnt_rd_data,
  input  logic              flag_clr,
  input  logic              xfer_start,
  input  logic              rsp_recv,
  input  logic              blk_done,
  input  logic              seq_done,
  input  logic              card_busy,
  output logic              stop_cmd_req,
  output logic [ARG_W-1:0]  stop_cmd_arg,
  output logic              auto_stop_flag
);

  logic stop_bit;
  logic bcen_bit;
  logic xfer_active;
  logic cnt_hit_zero;

  sd_stop_ctrl_reg #(.CTRL_W(CTRL_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctrl_wr_en),
    .wr_data (ctrl_wr_data),
    .stop_q  (stop_bit),
    .bcen_q  (bcen_bit),
    .rd_data (ctrl_rd_data)
  );

  sd_stop_blk_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (cnt_wr_en),
    .load_val (cnt_wr_data),
    .count_en (bcen_bit),
    .active   (xfer_active),
    .blk_done (blk_done),
    .cnt_q    (cnt_rd_data),
    .hit_zero (cnt_hit_zero)
  );

  sd_stop_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_q     (stop_bit),
    .hit_zero   (cnt_hit_zero),
    .xfer_start (xfer_start),
    .seq_done   (seq_done),
    .rsp_recv   (rsp_recv),
    .card_busy  (card_busy),
    .flag_clr   (flag_clr),
    .active     (xfer_active),
    .cmd_req    (stop_cmd_req),
    .flag_q     (auto_stop_flag)
  );

  // the stop command always carries a zero argument
  assign stop_cmd_arg = '0;

endmodule

// File: tb/sd_stop_sequencer_bench.sv
module sd_stop_sequencer_bench;

  localparam int unsigned CNT_W  = 4;
  localparam int unsigned CTRL_W = 16;
  localparam int unsigned ARG_W  = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ctrl_wr_en = 1'b0;
  logic [CTRL_W-1:0] ctrl_wr_data = '0;
  logic [CTRL_W-1:0] ctrl_rd_data;
  logic              cnt_wr_en = 1'b0;
  logic [CNT_W-1:0]  cnt_wr_data = '0;
  logic [CNT_W-1:0]  cnt_rd_data;
  logic              flag_clr = 1'b0;
  logic              xfer_start = 1'b0;
  logic              rsp_recv = 1'b0;
  logic              blk_done = 1'b0;
  logic              seq_done = 1'b0;
  logic              card_busy = 1'b0;
  logic              stop_cmd_req;
  logic [ARG_W-1:0]  stop_cmd_arg;
  logic              auto_stop_flag;

  sd_stop_sequencer #(.CNT_W(CNT_W), .CTRL_W(CTRL_W), .ARG_W(ARG_W)) u_sd_stop_sequencer (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data), .ctrl_rd_data(ctrl_rd_data),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data), .cnt_rd_data(cnt_rd_data),
    .flag_clr(flag_clr), .xfer_start(xfer_start), .rsp_recv(rsp_recv),
    .blk_done(blk_done), .seq_done(seq_done), .card_busy(card_busy),
    .stop_cmd_req(stop_cmd_req), .stop_cmd_arg(stop_cmd_arg), .auto_stop_flag(auto_stop_flag)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int req_pulses = 0;
  int wide_pulses = 0;
  int arg_bad = 0;
  int busy_reqs = 0;
  logic prev_req = 1'b0;
  logic done_flag = 1'b0;

  always @(negedge clk) begin
    if (stop_cmd_req) begin
      req_pulses++;
      if (prev_req) wide_pulses++;
      if (stop_cmd_arg != '0) arg_bad++;
      if (card_busy) busy_reqs++;
    end
    prev_req = stop_cmd_req;
  end

  // bench view of the control register read value
  function automatic logic [31:0] exp_ctrl(input logic [CTRL_W-1:0] w);
    logic [31:0] v;
    v = 32'h0;
    if (w[0]) v = v | 32'h1;
    if (w[8]) v = v | 32'h100;
    return v;
  endfunction

  function automatic logic [31:0] exp_left(input int n, input int blocks, input bit en);
    if (!en) return 32'(n);
    return (blocks >= n) ? 32'h0 : 32'(n - blocks);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [CTRL_W-1:0] d);
    ctrl_wr_data = d; ctrl_wr_en = 1'b1; cyc(1); ctrl_wr_en = 1'b0;
  endtask

  task automatic wr_cnt(input logic [CNT_W-1:0] v);
    cnt_wr_data = v; cnt_wr_en = 1'b1; cyc(1); cnt_wr_en = 1'b0;
  endtask

  task automatic p_start(); xfer_start = 1'b1; cyc(1); xfer_start = 1'b0; endtask
  task automatic p_blk();   blk_done   = 1'b1; cyc(1); blk_done   = 1'b0; endtask
  task automatic p_rsp();   rsp_recv   = 1'b1; cyc(1); rsp_recv   = 1'b0; endtask
  task automatic p_seq();   seq_done   = 1'b1; cyc(1); seq_done   = 1'b0; endtask
  task automatic p_clr();   flag_clr   = 1'b1; cyc(1); flag_clr   = 1'b0; endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'd20240611));
    cyc(3);
    // R1 reset state
    chk("R1 ctrl", 32'(ctrl_rd_data), 32'h0);
    chk("R1 cnt", 32'(cnt_rd_data), 32'h0);
    chk("R1 flag", 32'(auto_stop_flag), 32'h0);
    chk("R1 req", 32'(stop_cmd_req), 32'h0);
    rst_n = 1'b1;
    cyc(2);

    // R2 only bits 0 and 8 are kept
    wr_ctrl(16'hFFFF); chk("R2 all ones", 32'(ctrl_rd_data), exp_ctrl(16'hFFFF));
    wr_ctrl(16'hFEFE); chk("R2 reserved", 32'(ctrl_rd_data), exp_ctrl(16'hFEFE));
    wr_ctrl(16'h0100); chk("R2 bcen", 32'(ctrl_rd_data), exp_ctrl(16'h0100));
    wr_ctrl(16'h0000);

    // R3 stop bit during a transfer, R4 argument, R10 flag, R9 one request
    base = req_pulses;
    p_start(); cyc(2);
    wr_ctrl(16'h0001); cyc(4);
    chk("R3 stop request", 32'(req_pulses - base), 32'd1);
    chk("R10 flag before rsp", 32'(auto_stop_flag), 32'h0);
    p_rsp();
    chk("R10 flag set", 32'(auto_stop_flag), 32'h1);
    cyc(6);
    chk("R10 flag sticky", 32'(auto_stop_flag), 32'h1);
    chk("R9 no second request", 32'(req_pulses - base), 32'd1);
    p_start(); cyc(4);
    chk("R9 new transfer request", 32'(req_pulses - base), 32'd2);
    p_rsp(); p_clr();
    chk("R10 flag cleared", 32'(auto_stop_flag), 32'h0);
    wr_ctrl(16'h0000);

    // R6 counting disabled
    base = req_pulses;
    wr_cnt(4'd3); p_start();
    repeat (5) begin p_blk(); cyc(1); end
    cyc(3);
    chk("R6 count held", 32'(cnt_rd_data), 32'd3);
    chk("R6 no request", 32'(req_pulses - base), 32'd0);
    p_seq();

    // R5 counting enabled
    wr_ctrl(16'h0100); wr_cnt(4'd3); p_start();
    p_blk(); chk("R5 count 2", 32'(cnt_rd_data), exp_left(3, 1, 1'b1));
    p_blk(); chk("R5 count 1", 32'(cnt_rd_data), exp_left(3, 2, 1'b1));
    cyc(3); chk("R5 not yet", 32'(req_pulses - base), 32'd0);
    p_blk(); cyc(3);
    chk("R5 count 0", 32'(cnt_rd_data), 32'd0);
    chk("R5 request", 32'(req_pulses - base), 32'd1);
    p_rsp(); p_clr();

    // R7 stop after sequence completed
    base = req_pulses;
    wr_ctrl(16'h0000); wr_cnt(4'd9); p_start(); cyc(2); p_seq();
    wr_ctrl(16'h0001); cyc(6);
    chk("R7 no request", 32'(req_pulses - base), 32'd0);
    chk("R7 flag low", 32'(auto_stop_flag), 32'h0);
    wr_ctrl(16'h0000);

    // R8 busy holds the request
    wr_ctrl(16'h0100); wr_cnt(4'd1);
    card_busy = 1'b1; p_start(); p_blk(); cyc(10);
    chk("R8 held while busy", 32'(req_pulses - base), 32'd0);
    card_busy = 1'b0; cyc(3);
    chk("R8 issued after busy", 32'(req_pulses - base), 32'd1);
    p_rsp(); p_clr();

    // random transfers
    for (int it = 0; it < 60; it++) begin
      int n; int mode; int bl; int k;
      n = 2 + int'($urandom % 14);
      mode = int'($urandom % 3);
      bl = int'($urandom % 6);
      base = req_pulses;
      if (mode == 0) begin
        wr_ctrl(16'h0100); wr_cnt(CNT_W'(n)); p_start();
        for (int i = 0; i < n; i++) begin
          cyc(int'($urandom % 3));
          if (i == n - 1 && bl > 0) begin
            card_busy = 1'b1; p_blk(); cyc(bl);
            chk("R8 random busy", 32'(req_pulses - base), 32'd0);
            card_busy = 1'b0;
          end else p_blk();
        end
        cyc(3);
        chk("R5 random count", 32'(cnt_rd_data), exp_left(n, n, 1'b1));
        chk("R5 random request", 32'(req_pulses - base), 32'd1);
        p_rsp(); chk("R10 random flag", 32'(auto_stop_flag), 32'h1);
        p_clr(); chk("R10 random clear", 32'(auto_stop_flag), 32'h0);
      end else if (mode == 1) begin
        k = int'($urandom % 4);
        wr_ctrl(16'h0000); wr_cnt(CNT_W'(n)); p_start();
        for (int i = 0; i < k; i++) p_blk();
        chk("R6 random hold", 32'(cnt_rd_data), exp_left(n, k, 1'b0));
        if (bl > 0) card_busy = 1'b1;
        wr_ctrl(16'hFE01); cyc(bl + 1);
        if (bl > 0) chk("R8 random stop busy", 32'(req_pulses - base), 32'd0);
        card_busy = 1'b0; cyc(3);
        chk("R3 random stop", 32'(req_pulses - base), 32'd1);
        p_rsp(); p_clr(); wr_ctrl(16'h0000);
      end else begin
        wr_ctrl(16'h0100); wr_cnt(CNT_W'(n)); p_start();
        for (int i = 0; i < n - 1; i++) p_blk();
        chk("R5 random partial", 32'(cnt_rd_data), exp_left(n, n - 1, 1'b1));
        p_seq(); wr_ctrl(16'h0101); cyc(4);
        chk("R7 random ended", 32'(req_pulses - base), 32'd0);
        wr_ctrl(16'h0000);
      end
    end

    chk("R4 argument zero", 32'(arg_bad), 32'd0);
    chk("R9 pulse width", 32'(wide_pulses), 32'd0);
    chk("R8 no request while busy", 32'(busy_reqs), 32'd0);
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule